// File: doc/BRIEF.md
# Timer-Shared General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port in which some pins are also used by two timers: a 16-bit free-running timer and an 8-bit timer. Software sees two registers on a small register bus. One is a data latch and the other is a direction mask in which a 1 makes a pin an output. The pads connect through a per-pin output value, a per-pin output enable and a pad input. Each pad input passes through a two-flop synchronizer before it is used.

Every pin resolves to an effective level. An output pin takes its level from the latch and an input pin takes it from the synchronized pad. Both software readback and the timer clock and reset inputs use this effective level. The three capture inputs of the 16-bit timer always follow the synchronized pad. Pin 1 and pin 4 can be taken over by timer compare outputs. While a takeover is active, the pad is driven by the timer, and the latch and direction bits for that pin have no effect on the pad.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset, the data latch and direction register are 0, every pad output enable is 0 while no timer override is active, and a data read returns the synchronized pad level, which is 0 until pad values arrive.
- R2: A write with we_i=1 to address 0 loads the data latch on the next clock edge. For pins whose direction bit is 1, a read of address 0 then returns the latch bits.
- R3: A write to address 1 loads the direction register on the next edge, and reading address 1 returns it. Writes to addresses 2 and 3 change neither register.
- R4: For pins whose direction bit is 0, a read of address 0 returns the pad level delayed by two clock edges.
- R5: On a pin with no active override, pad_oe_o equals the direction bit and pad_out_o equals the latch bit.
- R6: While frt_oe_i=1, pin 1 has pad_oe_o=1 and pad_out_o=frt_cmp_i, whatever its latch and direction bits are.
- R7: While tmr_os_i is nonzero, pin 4 has pad_oe_o=1 and pad_out_o=tmr_cmp_i. When tmr_os_i=0, pin 4 reverts to R5.
- R8: frt_clk_o and tmr_clk_o both carry the effective level of pin 0. This is the latch bit if the pin's direction bit is 1, and the synchronized pad otherwise.
- R9: tmr_rst_o carries the effective level of pin 3, following the same latch-or-pad rule as R8.
- R10: cap_a_o, cap_b_o and cap_c_o carry the synchronized pad levels of pins 2, 3 and 4 whatever their direction bits are.
- R11: A read of address 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address: 0 data, 1 direction |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |
| frt_clk_o | output | 1 | External clock to the 16-bit timer |
| tmr_clk_o | output | 1 | External clock to the 8-bit timer |
| tmr_rst_o | output | 1 | Reset input to the 8-bit timer |
| cap_a_o | output | 1 | Capture input A of the 16-bit timer |
| cap_b_o | output | 1 | Capture input B of the 16-bit timer |
| cap_c_o | output | 1 | Capture input C of the 16-bit timer |
| frt_cmp_i | input | 1 | Compare output of the 16-bit timer |
| frt_oe_i | input | 1 | Output enable of the 16-bit timer, overrides pin 1 |
| tmr_cmp_i | input | 1 | Compare output of the 8-bit timer |
| tmr_os_i | input | 2 | Output select of the 8-bit timer; nonzero overrides pin 4 |

## Verification
The assertions check on every cycle that:
- both timer overrides take the pad;
- register writes reach the pad enables and values one edge later;
- output-pin readback matches the driven latch;
- unmapped reads give zero;
- the timer clock and reset follow the driven value on output pins;
- the capture lines equal the pad level from two edges earlier.

Some behaviour only the bench scenarios can show:
- the synchronizer latency seen in readback, one edge after a pad change versus two;
- the switch of the timer clock and reset from pad to latch when a direction bit is set;
- an ignored unmapped write, seen by reading back both registers;
- the override on pin 4 falling away when the output select returns to zero.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PIN_W      = 8;
  localparam int unsigned ADDR_W     = 2;
  localparam int unsigned OS_W       = 2;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned ADDR_DATA  = 0;
  localparam int unsigned ADDR_DIR   = 1;
  localparam int unsigned PIN_CLK    = 0;
  localparam int unsigned PIN_FRT_OUT = 1;
  localparam int unsigned PIN_CAP_A  = 2;
  localparam int unsigned PIN_CAP_B  = 3;
  localparam int unsigned PIN_TRST   = 3;
  localparam int unsigned PIN_CAP_C  = 4;
  localparam int unsigned PIN_TMR_OUT = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned AW        = 2,
  parameter int unsigned DATA_ADDR = 0,
  parameter int unsigned DIR_ADDR  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  data_q_o,
  output logic [W-1:0]  dir_q_o,
  output reg_sel_e      sel_o
);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_ADDR);
  localparam logic [AW-1:0] A_DIR  = AW'(DIR_ADDR);

  logic [W-1:0] data_q, dir_q;

  always_comb begin
    if (addr_i == A_DATA)     sel_o = SEL_DATA;
    else if (addr_i == A_DIR) sel_o = SEL_DIR;
    else                      sel_o = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (we_i) begin
      if (sel_o == SEL_DATA) data_q <= wdata_i;
      if (sel_o == SEL_DIR)  dir_q  <= wdata_i;
    end
  end

  assign data_q_o = data_q;
  assign dir_q_o  = dir_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W       = 8,
  parameter int unsigned OSW     = 2,
  parameter int unsigned FRT_PIN = 1,
  parameter int unsigned TMR_PIN = 4
) (
  input  logic [W-1:0]   data_i,
  input  logic [W-1:0]   dir_i,
  input  logic [W-1:0]   sync_i,
  input  logic           frt_cmp_i,
  input  logic           frt_oe_i,
  input  logic           tmr_cmp_i,
  input  logic [OSW-1:0] tmr_os_i,
  output logic [W-1:0]   pad_out_o,
  output logic [W-1:0]   pad_oe_o,
  output logic [W-1:0]   eff_o
);
  logic [W-1:0] ovr, alt;
  logic         tmr_take;

  assign tmr_take = |tmr_os_i;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == FRT_PIN) begin : g_frt
      assign ovr[i] = frt_oe_i;
      assign alt[i] = frt_cmp_i;
    end else if (i == TMR_PIN) begin : g_tmr
      assign ovr[i] = tmr_take;
      assign alt[i] = tmr_cmp_i;
    end else begin : g_plain
      assign ovr[i] = 1'b0;
      assign alt[i] = 1'b0;
    end
    assign pad_oe_o[i]  = ovr[i] | dir_i[i];
    assign pad_out_o[i] = ovr[i] ? alt[i] : data_i[i];
    // latch for outputs, pad for inputs
    assign eff_o[i]     = dir_i[i] ? data_i[i] : sync_i[i];
  end
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS  = PIN_W,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned OSW     = OS_W,
  parameter int unsigned SYNC_N  = SYNC_DEPTH,
  parameter int unsigned CLK_PIN = PIN_CLK,
  parameter int unsigned FRT_PIN = PIN_FRT_OUT,
  parameter int unsigned TMR_PIN = PIN_TMR_OUT,
  parameter int unsigned RST_PIN = PIN_TRST,
  parameter int unsigned CA_PIN  = PIN_CAP_A,
  parameter int unsigned CB_PIN  = PIN_CAP_B,
  parameter int unsigned CC_PIN  = PIN_CAP_C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              frt_clk_o,
  output logic              tmr_clk_o,
  output logic              tmr_rst_o,
  output logic              cap_a_o,
  output logic              cap_b_o,
  output logic              cap_c_o,
  input  logic              frt_cmp_i,
  input  logic              frt_oe_i,
  input  logic              tmr_cmp_i,
  input  logic [OSW-1:0]    tmr_os_i
);
  logic [N_PINS-1:0] sync_q, data_q, dir_q, eff;
  reg_sel_e          sel;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_q)
  );

  gpio_regs #(
    .W(N_PINS), .AW(AW), .DATA_ADDR(ADDR_DATA), .DIR_ADDR(ADDR_DIR)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .data_q_o(data_q),
    .dir_q_o (dir_q),
    .sel_o   (sel)
  );

  gpio_pin_mux #(
    .W(N_PINS), .OSW(OSW), .FRT_PIN(FRT_PIN), .TMR_PIN(TMR_PIN)
  ) u_mux (
    .data_i   (data_q),
    .dir_i    (dir_q),
    .sync_i   (sync_q),
    .frt_cmp_i(frt_cmp_i),
    .frt_oe_i (frt_oe_i),
    .tmr_cmp_i(tmr_cmp_i),
    .tmr_os_i (tmr_os_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o),
    .eff_o    (eff)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = eff;
      SEL_DIR:  rdata_o = dir_q;
      default:  rdata_o = '0;
    endcase
  end

  // timer clock/reset see latch when the pin is an output
  assign frt_clk_o = eff[CLK_PIN];
  assign tmr_clk_o = eff[CLK_PIN];
  assign tmr_rst_o = eff[RST_PIN];
  // capture inputs always see the pad
  assign cap_a_o   = sync_q[CA_PIN];
  assign cap_b_o   = sync_q[CB_PIN];
  assign cap_c_o   = sync_q[CC_PIN];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS  = 8,
  parameter int unsigned AW      = 2,
  parameter int unsigned OSW     = 2,
  parameter int unsigned CLK_PIN = 0,
  parameter int unsigned FRT_PIN = 1,
  parameter int unsigned TMR_PIN = 4,
  parameter int unsigned RST_PIN = 3,
  parameter int unsigned CA_PIN  = 2,
  parameter int unsigned CB_PIN  = 3,
  parameter int unsigned CC_PIN  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              we_i,
  input logic [N_PINS-1:0] wdata_i,
  input logic [N_PINS-1:0] rdata_o,
  input logic [N_PINS-1:0] pad_in_i,
  input logic [N_PINS-1:0] pad_out_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              frt_clk_o,
  input logic              tmr_clk_o,
  input logic              tmr_rst_o,
  input logic              cap_a_o,
  input logic              cap_b_o,
  input logic              cap_c_o,
  input logic              frt_cmp_i,
  input logic              frt_oe_i,
  input logic              tmr_cmp_i,
  input logic [OSW-1:0]    tmr_os_i
);
  localparam logic [N_PINS-1:0] ONE   = N_PINS'(1);
  localparam logic [N_PINS-1:0] PLAIN = ~((ONE << FRT_PIN) | (ONE << TMR_PIN));
  localparam logic [AW-1:0]     A_DATA = AW'(ADDR_DATA);
  localparam logic [AW-1:0]     A_DIR  = AW'(ADDR_DIR);

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  AST_DATA_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DATA) |=> ((pad_out_o & PLAIN) == ($past(wdata_i) & PLAIN))); // R2
  AST_OUT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_DATA) |-> ((rdata_o & pad_oe_o & PLAIN) == (pad_out_o & pad_oe_o & PLAIN))); // R2
  AST_DIR_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIR) |=> ((pad_oe_o & PLAIN) == ($past(wdata_i) & PLAIN))); // R5
  AST_FRT_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frt_oe_i |-> (pad_oe_o[FRT_PIN] && pad_out_o[FRT_PIN] == frt_cmp_i)); // R6
  AST_TMR_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_os_i != '0) |-> (pad_oe_o[TMR_PIN] && pad_out_o[TMR_PIN] == tmr_cmp_i)); // R7
  AST_CLK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[CLK_PIN] |-> (frt_clk_o == pad_out_o[CLK_PIN] && tmr_clk_o == frt_clk_o)); // R8
  AST_TRST_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o[RST_PIN] |-> (tmr_rst_o == pad_out_o[RST_PIN])); // R9
  AST_CAP_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (cap_a_o == $past(pad_in_i[CA_PIN], 2))); // R10
  AST_CAP_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (cap_b_o == $past(pad_in_i[CB_PIN], 2))); // R10
  AST_CAP_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> (cap_c_o == $past(pad_in_i[CC_PIN], 2))); // R10
  AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != A_DATA && addr_i != A_DIR) |-> (rdata_o == '0)); // R11
endmodule

bind gpio_altfn_port gpio_port_chk #(
  .N_PINS(N_PINS), .AW(AW), .OSW(OSW), .CLK_PIN(CLK_PIN), .FRT_PIN(FRT_PIN),
  .TMR_PIN(TMR_PIN), .RST_PIN(RST_PIN), .CA_PIN(CA_PIN), .CB_PIN(CB_PIN), .CC_PIN(CC_PIN)
) u_chk (.*);

// File: tb/gpio_altfn_port_tb_top.sv
module gpio_altfn_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;
  logic       frt_clk, tmr_clk, tmr_rst, cap_a, cap_b, cap_c;
  logic       frt_cmp = 1'b0, frt_oe = 1'b0, tmr_cmp = 1'b0;
  logic [1:0] tmr_os = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_altfn_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .frt_clk_o(frt_clk), .tmr_clk_o(tmr_clk), .tmr_rst_o(tmr_rst),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .cap_c_o(cap_c),
    .frt_cmp_i(frt_cmp), .frt_oe_i(frt_oe), .tmr_cmp_i(tmr_cmp), .tmr_os_i(tmr_os)
  );

  // reference model
  logic [7:0] m_data, m_dir;
  logic [7:0] m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_dir = '0;
      m_hist = {8'h00, 8'h00};
    end else begin
      if (we && addr == 2'd0) m_data = wdata;
      if (we && addr == 2'd1) m_dir = wdata;
      void'(m_hist.pop_front());
      m_hist.push_back(pad_in);
    end
  end

  function automatic logic [7:0] m_sync();
    return (m_hist.size() == 2) ? m_hist[0] : 8'h00;
  endfunction

  function automatic logic [7:0] m_eff();
    logic [7:0] e;
    for (int i = 0; i < 8; i++) e[i] = m_dir[i] ? m_data[i] : m_sync()[i];
    return e;
  endfunction

  function automatic logic [7:0] m_rdata();
    case (addr)
      2'd0:    return m_eff();
      2'd1:    return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_oe();
    logic [7:0] o = m_dir;
    if (frt_oe) o[1] = 1'b1;
    if (tmr_os != 2'b00) o[4] = 1'b1;
    return o;
  endfunction

  function automatic logic [7:0] m_out();
    logic [7:0] o = m_data;
    if (frt_oe) o[1] = frt_cmp;
    if (tmr_os != 2'b00) o[4] = tmr_cmp;
    return o;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R4 rdata vs model", 32'(rdata), 32'(m_rdata()));
      chk("R5 pad_oe vs model", 32'(pad_oe), 32'(m_oe()));
      chk("R5 pad_out vs model", 32'(pad_out), 32'(m_out()));
      chk("R8 timer clocks vs model", {30'd0, frt_clk, tmr_clk}, {30'd0, m_eff()[0], m_eff()[0]});
      chk("R9 timer reset vs model", 32'(tmr_rst), 32'(m_eff()[3]));
      chk("R10 captures vs model", {29'd0, cap_a, cap_b, cap_c},
          {29'd0, m_sync()[2], m_sync()[3], m_sync()[4]});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic wait_sync();
    repeat (2) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    addr = 2'd0; #1;
    chk("R1 data read after reset", 32'(rdata), 32'h00);
    chk("R1 pad_oe after reset", 32'(pad_oe), 32'h00);
    addr = 2'd1; #1;
    chk("R1 dir read after reset", 32'(rdata), 32'h00);

    pad_in = 8'h3C;
    bus_wr(2'd1, 8'h0F);
    bus_wr(2'd0, 8'hA5);
    addr = 2'd1; #1;
    chk("R3 dir readback", 32'(rdata), 32'h0F);
    chk("R5 pad_oe follows dir", 32'(pad_oe), 32'h0F);
    chk("R5 pad_out follows latch", 32'(pad_out), 32'hA5);
    addr = 2'd0; #1;
    chk("R2 mixed readback", 32'(rdata), 32'h35);

    // R4 two-edge latency
    pad_in = 8'hC3;
    @(negedge clk); #1;
    chk("R4 one edge after pad change", 32'(rdata), 32'h35);
    @(negedge clk); #1;
    chk("R4 two edges after pad change", 32'(rdata), 32'hC5);

    // R3 / R11 unmapped address
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd3, 8'hFF);
    addr = 2'd1; #1;
    chk("R3 dir untouched by unmapped write", 32'(rdata), 32'h0F);
    chk("R3 latch untouched by unmapped write", 32'(pad_out), 32'hA5);
    addr = 2'd2; #1;
    chk("R11 unmapped read addr2", 32'(rdata), 32'h00);
    addr = 2'd3; #1;
    chk("R11 unmapped read addr3", 32'(rdata), 32'h00);

    // R8 clock pin
    bus_wr(2'd0, 8'hA4);
    bus_wr(2'd1, 8'h00);
    pad_in = 8'h01;
    wait_sync();
    chk("R8 clock from pad (input)", {30'd0, frt_clk, tmr_clk}, 32'h3);
    bus_wr(2'd1, 8'h01);
    chk("R8 clock from latch (output)", {30'd0, frt_clk, tmr_clk}, 32'h0);

    // R9 reset pin
    bus_wr(2'd1, 8'h00);
    pad_in = 8'h08;
    wait_sync();
    chk("R9 timer reset from pad", 32'(tmr_rst), 32'h1);
    bus_wr(2'd1, 8'h08);
    chk("R9 timer reset from latch", 32'(tmr_rst), 32'h0);

    // R10 captures while all pins are outputs
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd0, 8'h00);
    pad_in = 8'h1C;
    wait_sync();
    chk("R10 captures follow pad", {29'd0, cap_a, cap_b, cap_c}, 32'h7);

    // R6 16-bit timer takeover of pin 1
    bus_wr(2'd1, 8'h00);
    frt_oe = 1'b1; frt_cmp = 1'b1; #1;
    chk("R6 pin1 oe under takeover", 32'(pad_oe[1]), 32'h1);
    chk("R6 pin1 value under takeover", 32'(pad_out[1]), 32'h1);
    bus_wr(2'd1, 8'h02);
    frt_cmp = 1'b0; #1;
    chk("R6 pin1 ignores latch", 32'(pad_out[1]), 32'h0);
    frt_cmp = 1'b1; #1;
    chk("R6 pin1 tracks compare", 32'(pad_out[1]), 32'h1);
    frt_oe = 1'b0; #1;
    chk("R6 pin1 back to latch", 32'(pad_out[1]), 32'h0);

    // R7 8-bit timer takeover of pin 4
    tmr_os = 2'b01; tmr_cmp = 1'b1; #1;
    chk("R7 pin4 oe under select", 32'(pad_oe[4]), 32'h1);
    chk("R7 pin4 value under select", 32'(pad_out[4]), 32'h1);
    tmr_os = 2'b10; tmr_cmp = 1'b0; #1;
    chk("R7 pin4 other select code", {30'd0, pad_oe[4], pad_out[4]}, 32'h2);
    tmr_os = 2'b00; #1;
    chk("R7 pin4 released", 32'(pad_oe[4]), 32'h0);

    repeat (3) @(negedge clk);
    #1;
    finish_run();
  end
endmodule